// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block holds recently used page translations for a memory management unit. Every entry is compared against the lookup key at the same time. Combinational logic then returns one of three outcomes in the same cycle as the request:

- a hit, which carries the physical frame number;
- a miss;
- a fault, which means the mapping exists but the access is not allowed.

The lookup key is a virtual page number together with the identifier of the running address space. The permission check uses the access type (read or write) and the privilege mode (user or kernel).

Every entry carries the identifier of its address space. Translations that belong to different processes can therefore stay resident together, and a context switch needs no flush.

A page walker outside the block supplies refills. Refill placement works as follows:

- A refill whose page and identifier already exist rewrites that entry in place.
- Otherwise the lowest-numbered empty slot is used.
- When there is no empty slot, a round-robin pointer chooses the victim and steps over pinned entries.

Software can remove the single entry that matches a page and identifier. It can also flush every entry that is not pinned. A refill can pin its entry, so that mappings such as the kernel's stay resident through flushes and replacement.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry is empty, and any lookup reports a miss with frame output 0.
- R2: A lookup hits only when the page number and the address-space identifier of a valid entry both equal the request. The frame of that entry appears on `lk_pfn` in the same cycle.
- R3: An access to a matching entry is permitted when both conditions hold: a read (`lk_write`=0) needs the entry's read bit and a write (`lk_write`=1) needs its write bit, and user mode (`lk_user`=1) needs the entry's user bit. A matching access that is not permitted raises `lk_fault` instead of `lk_hit`, and `lk_pfn` is 0.
- R4: A refill accepted at a clock edge is visible to a lookup in the next cycle.
- R5: A refill whose page and identifier match an existing valid entry rewrites that entry in place. It consumes no other slot, so no two valid entries ever share a key.
- R6: A refill of a new key goes into the lowest-numbered empty entry, whatever the round-robin pointer holds.
- R7: When all entries are valid, a new refill replaces the first unpinned entry at or after the round-robin pointer, wrapping around. The pointer starts at entry 0 after reset and then moves to the entry after the victim.
- R8: An invalidate request removes the entry matching its page and identifier, including a pinned one, and leaves every other entry untouched.
- R9: A flush removes every unpinned entry. Pinned entries stay valid and unchanged.
- R10: Maintenance requests in one cycle are ordered flush, then invalidate, then refill. Only the highest one present takes effect.
- R11: With `lk_valid` high exactly one of `lk_hit`, `lk_miss` and `lk_fault` is 1. With `lk_valid` low all three are 0.
- R12: A refill of a new key is dropped when every entry is valid and pinned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space identifier of the running process |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_hit | output | 1 | Permitted translation found |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry forbids this access |
| lk_pfn | output | PFN_W | Physical frame on a hit, else 0 |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VPN_W | Refill page number |
| rf_asid | input | ASID_W | Refill identifier |
| rf_pfn | input | PFN_W | Refill frame number |
| rf_rd | input | 1 | Read allowed |
| rf_wr | input | 1 | Write allowed |
| rf_usr | input | 1 | User mode allowed |
| rf_pin | input | 1 | Pin the entry against flush and replacement |
| inv_valid | input | 1 | Invalidate-one request |
| inv_vpn | input | VPN_W | Page number to invalidate |
| inv_asid | input | ASID_W | Identifier to invalidate |
| flush | input | 1 | Remove all unpinned entries |

## Verification
Some properties are checked by assertions on every cycle:

- exactly one lookup outcome per request and silence when there is no request;
- a frame output of 0 on a fault;
- no two entries ever matching one key;
- a refill landing in the entry it chose;
- a flush leaving only pinned entries behind.

Other behaviour only the directed scenarios can show:

- victim order: empty slots first, then the round-robin pointer stepping past a pinned entry;
- identifier isolation;
- the permission matrix;
- in-place rewrite;
- the ordering of simultaneous maintenance requests;
- a refill dropped when every entry is pinned.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

    typedef enum logic [1:0] {
        MT_NONE  = 2'd0,
        MT_FILL  = 2'd1,
        MT_INVAL = 2'd2,
        MT_FLUSH = 2'd3
    } maint_e;

    // Flush wins over invalidate, invalidate wins over refill.
    function automatic maint_e pick_maint(input logic fl, input logic iv, input logic fi);
        if (fl)      return MT_FLUSH;
        else if (iv) return MT_INVAL;
        else if (fi) return MT_FILL;
        else         return MT_NONE;
    endfunction

endpackage

// File: rtl/xlat_tlb_match.sv
module xlat_tlb_match #(
    parameter int N     = 48,
    parameter int KEY_W = 28
) (
    input  logic [KEY_W-1:0]        key,
    input  logic [N-1:0][KEY_W-1:0] tags,
    input  logic [N-1:0]            vld,
    output logic [N-1:0]            hits
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = vld[g] && (tags[g] == key);
    end
endmodule

// File: rtl/xlat_tlb_prio.sv
module xlat_tlb_prio #(
    parameter int N     = 48,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xlat_tlb_victim.sv
module xlat_tlb_victim #(
    parameter int N     = 48,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     pin,
    input  logic [IDX_W-1:0] ptr,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int c;
            c = int'(ptr) + k;
            if (c >= N) c = c - N;
            if (!pin[c]) begin
                found = 1'b1;
                idx   = IDX_W'(c);
            end
        end
    end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_user,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [PFN_W-1:0]  lk_pfn,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic              rf_rd,
    input  logic              rf_wr,
    input  logic              rf_usr,
    input  logic              rf_pin,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic              flush
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int KEY_W = VPN_W + ASID_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic              rd;
        logic              wr;
        logic              usr;
    } entry_t;

    typedef struct packed {
        logic [ENTRIES-1:0]         vld;
        logic [ENTRIES-1:0]         pin;
        entry_t [ENTRIES-1:0]       ent;
        logic [IDX_W-1:0]           ptr;
    } state_t;

    state_t s_q, s_d;

    logic [ENTRIES-1:0][KEY_W-1:0] tags;
    for (genvar g = 0; g < ENTRIES; g++) begin : g_tag
        assign tags[g] = {s_q.ent[g].vpn, s_q.ent[g].asid};
    end

    // Lookup path.
    logic [ENTRIES-1:0] lk_hits;
    logic               lk_found;
    logic [IDX_W-1:0]   lk_idx;

    xlat_tlb_match #(.N(ENTRIES), .KEY_W(KEY_W)) i_lk_match (
        .key  ({lk_vpn, lk_asid}),
        .tags (tags),
        .vld  (s_q.vld),
        .hits (lk_hits)
    );

    xlat_tlb_prio #(.N(ENTRIES), .IDX_W(IDX_W)) i_lk_prio (
        .req   (lk_hits),
        .found (lk_found),
        .idx   (lk_idx)
    );

    entry_t lk_ent;
    logic   lk_ok;

    always_comb begin
        lk_ent   = s_q.ent[lk_idx];
        lk_ok    = (lk_write ? lk_ent.wr : lk_ent.rd) && (!lk_user || lk_ent.usr);
        lk_hit   = lk_valid && lk_found && lk_ok;
        lk_fault = lk_valid && lk_found && !lk_ok;
        lk_miss  = lk_valid && !lk_found;
        lk_pfn   = lk_hit ? lk_ent.pfn : '0;
    end

    // Maintenance path: invalidate key when invalidating, else refill key.
    maint_e             op;
    logic [KEY_W-1:0]   mt_key;
    logic [ENTRIES-1:0] mt_hits;
    logic               mt_found;
    logic [IDX_W-1:0]   mt_idx;
    logic               free_found;
    logic [IDX_W-1:0]   free_idx;
    logic               vict_found;
    logic [IDX_W-1:0]   vict_idx;

    assign op     = pick_maint(flush, inv_valid, rf_valid);
    assign mt_key = (op == MT_INVAL) ? {inv_vpn, inv_asid} : {rf_vpn, rf_asid};

    xlat_tlb_match #(.N(ENTRIES), .KEY_W(KEY_W)) i_mt_match (
        .key  (mt_key),
        .tags (tags),
        .vld  (s_q.vld),
        .hits (mt_hits)
    );

    xlat_tlb_prio #(.N(ENTRIES), .IDX_W(IDX_W)) i_mt_prio (
        .req   (mt_hits),
        .found (mt_found),
        .idx   (mt_idx)
    );

    xlat_tlb_prio #(.N(ENTRIES), .IDX_W(IDX_W)) i_free_prio (
        .req   (~s_q.vld),
        .found (free_found),
        .idx   (free_idx)
    );

    xlat_tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) i_victim (
        .pin   (s_q.pin),
        .ptr   (s_q.ptr),
        .found (vict_found),
        .idx   (vict_idx)
    );

    logic             fill_fire;
    logic [IDX_W-1:0] fill_idx;
    entry_t           new_ent;

    always_comb begin
        s_d       = s_q;
        fill_fire = 1'b0;
        fill_idx  = '0;
        new_ent   = '{vpn: rf_vpn, asid: rf_asid, pfn: rf_pfn,
                      rd: rf_rd, wr: rf_wr, usr: rf_usr};
        case (op)
            MT_FLUSH: begin
                s_d.vld = s_q.vld & s_q.pin;
            end
            MT_INVAL: begin
                if (mt_found) begin
                    s_d.vld[mt_idx] = 1'b0;
                    s_d.pin[mt_idx] = 1'b0;
                end
            end
            MT_FILL: begin
                if (mt_found) begin
                    fill_fire = 1'b1;
                    fill_idx  = mt_idx;
                end else if (free_found) begin
                    fill_fire = 1'b1;
                    fill_idx  = free_idx;
                end else if (vict_found) begin
                    fill_fire = 1'b1;
                    fill_idx  = vict_idx;
                    s_d.ptr   = (vict_idx == LAST) ? '0 : vict_idx + 1'b1;
                end
                if (fill_fire) begin
                    s_d.ent[fill_idx] = new_ent;
                    s_d.vld[fill_idx] = 1'b1;
                    s_d.pin[fill_idx] = rf_pin;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.vld <= '0;
            s_q.pin <= '0;
            s_q.ent <= '0;
            s_q.ptr <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Assertions.
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot({lk_hit, lk_miss, lk_fault}));

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    p_fault_no_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_pfn == '0));

    p_no_duplicate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lk_hits) <= 1) && ($countones(mt_hits) <= 1));

    p_fill_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_fire |=> s_q.vld[$past(fill_idx)] &&
                      (s_q.ent[$past(fill_idx)].pfn == $past(rf_pfn)));

    p_flush_keeps_pinned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MT_FLUSH) |=> ((s_q.vld & ~s_q.pin) == '0) && (s_q.pin == $past(s_q.pin)));

    p_pinned_is_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pin & ~s_q.vld) == '0);

endmodule

// File: tb/test_xlat_tlb.sv
`timescale 1ns/1ps
module test_xlat_tlb;
    localparam int N      = 48;
    localparam int VPN_W  = 20;
    localparam int ASID_W = 8;
    localparam int PFN_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0, lk_user = 0, lk_write = 0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic lk_hit, lk_miss, lk_fault;
    logic [PFN_W-1:0] lk_pfn;
    logic rf_valid = 0, rf_rd = 0, rf_wr = 0, rf_usr = 0, rf_pin = 0;
    logic [VPN_W-1:0] rf_vpn = '0;
    logic [ASID_W-1:0] rf_asid = '0;
    logic [PFN_W-1:0] rf_pfn = '0;
    logic inv_valid = 0, flush = 0;
    logic [VPN_W-1:0] inv_vpn = '0;
    logic [ASID_W-1:0] inv_asid = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xlat_tlb #(.ENTRIES(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) i_xlat_tlb (
        .clk, .rst_n, .lk_valid, .lk_vpn, .lk_asid, .lk_user, .lk_write,
        .lk_hit, .lk_miss, .lk_fault, .lk_pfn,
        .rf_valid, .rf_vpn, .rf_asid, .rf_pfn, .rf_rd, .rf_wr, .rf_usr, .rf_pin,
        .inv_valid, .inv_vpn, .inv_asid, .flush
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One maintenance cycle; invalidate key equals refill key.
    task automatic pulse(input bit fl, input bit iv, input bit fi,
                         input int vpn, input int asid, input int pfn,
                         input bit rd, input bit wr, input bit usr, input bit pin);
        @(negedge clk);
        flush = fl; inv_valid = iv; rf_valid = fi;
        rf_vpn = VPN_W'(vpn); rf_asid = ASID_W'(asid); rf_pfn = PFN_W'(pfn);
        rf_rd = rd; rf_wr = wr; rf_usr = usr; rf_pin = pin;
        inv_vpn = VPN_W'(vpn); inv_asid = ASID_W'(asid);
        @(posedge clk);
        @(negedge clk);
        flush = 0; inv_valid = 0; rf_valid = 0;
    endtask

    task automatic fill(input int vpn, input int asid, input int pfn,
                        input bit rd, input bit wr, input bit usr, input bit pin);
        pulse(0, 0, 1, vpn, asid, pfn, rd, wr, usr, pin);
    endtask

    // exp: 0 = miss, 1 = hit, 2 = fault
    task automatic look(input string req, input int vpn, input int asid,
                        input bit user, input bit wr, input int exp, input int pfn);
        logic [3+PFN_W-1:0] e;
        lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid);
        lk_user = user; lk_write = wr;
        #1;
        e = {exp == 1, exp == 0, exp == 2, (exp == 1) ? PFN_W'(pfn) : PFN_W'(0)};
        chk(req, 64'({lk_hit, lk_miss, lk_fault, lk_pfn}), 64'(e));
        lk_valid = 0;
        #1;
    endtask

    task automatic t_reset();
        look("R1 empty after reset", 'h100, 1, 0, 0, 0, 0);
        look("R1 empty other key", 'h0, 0, 1, 1, 0, 0);
    endtask

    task automatic t_idle();
        lk_valid = 0; #1;
        chk("R11 idle outputs", 64'({lk_hit, lk_miss, lk_fault}), 64'(0));
    endtask

    task automatic t_basic();
        fill('h100, 1, 'h0AB, 1, 1, 1, 0);
        look("R4 R2 hit next cycle", 'h100, 1, 1, 1, 1, 'h0AB);
        look("R2 asid mismatch", 'h100, 2, 0, 0, 0, 0);
        look("R2 vpn mismatch", 'h101, 1, 0, 0, 0, 0);
    endtask

    task automatic t_perm();
        fill('h200, 1, 'h022, 1, 0, 0, 0);
        look("R3 kernel read ok", 'h200, 1, 0, 0, 1, 'h022);
        look("R3 write to read-only", 'h200, 1, 0, 1, 2, 0);
        look("R3 user on kernel page", 'h200, 1, 1, 0, 2, 0);
        fill('h210, 1, 'h023, 0, 1, 1, 0);
        look("R3 read on write-only", 'h210, 1, 1, 0, 2, 0);
        look("R3 user write ok", 'h210, 1, 1, 1, 1, 'h023);
    endtask

    task automatic t_update();
        fill('h100, 1, 'h0CD, 1, 1, 1, 0);
        look("R5 in-place new frame", 'h100, 1, 0, 0, 1, 'h0CD);
    endtask

    task automatic t_inval();
        pulse(0, 1, 0, 'h100, 1, 0, 0, 0, 0, 0);
        look("R8 invalidated entry", 'h100, 1, 0, 0, 0, 0);
        look("R8 neighbour kept", 'h200, 1, 0, 0, 1, 'h022);
    endtask

    task automatic t_flush();
        fill('h300, 0, 'h033, 1, 1, 0, 1);
        pulse(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        look("R9 pinned survives flush", 'h300, 0, 0, 0, 1, 'h033);
        look("R9 unpinned flushed", 'h200, 1, 0, 0, 0, 0);
        pulse(0, 1, 0, 'h300, 0, 0, 0, 0, 0, 0);
        look("R8 pinned invalidated", 'h300, 0, 0, 0, 0, 0);
    endtask

    task automatic t_prio();
        pulse(1, 0, 1, 'h400, 2, 'h044, 1, 1, 1, 0);
        look("R10 flush beats refill", 'h400, 2, 0, 0, 0, 0);
        fill('h410, 2, 'h045, 1, 1, 1, 0);
        pulse(0, 1, 1, 'h410, 2, 'h046, 1, 1, 1, 0);
        look("R10 invalidate beats refill", 'h410, 2, 0, 0, 0, 0);
        fill('h420, 2, 'h047, 1, 1, 1, 1);
        pulse(1, 1, 0, 'h420, 2, 0, 0, 0, 0, 0);
        look("R10 flush beats invalidate", 'h420, 2, 0, 0, 1, 'h047);
    endtask

    task automatic t_replace();
        do_reset();
        for (int i = 0; i < N; i++) fill('h1000 + i, 3, i, 1, 1, 1, i == 2);
        for (int i = 0; i < N; i++) begin
            lk_valid = 1; lk_vpn = VPN_W'('h1000 + i); lk_asid = 3;
            lk_user = 0; lk_write = 0; #1;
            chk("R6 all slots filled", 64'(lk_hit), 64'(1));
            lk_valid = 0;
        end
        fill('h2000, 3, 'h200, 1, 1, 1, 0);
        look("R7 victim entry 0", 'h1000, 3, 0, 0, 0, 0);
        look("R7 new entry hits", 'h2000, 3, 0, 0, 1, 'h200);
        look("R7 entry 1 kept", 'h1001, 3, 0, 0, 1, 1);
        fill('h2001, 3, 'h201, 1, 1, 1, 0);
        look("R7 victim entry 1", 'h1001, 3, 0, 0, 0, 0);
        fill('h2002, 3, 'h202, 1, 1, 1, 0);
        look("R7 pinned entry 2 skipped", 'h1002, 3, 0, 0, 1, 2);
        look("R7 victim entry 3", 'h1003, 3, 0, 0, 0, 0);
        pulse(0, 1, 0, 'h1010, 3, 0, 0, 0, 0, 0);
        fill('h2003, 3, 'h203, 1, 1, 1, 0);
        look("R6 empty slot used first", 'h2003, 3, 0, 0, 1, 'h203);
        look("R6 pointer entry 4 kept", 'h1004, 3, 0, 0, 1, 4);
    endtask

    task automatic t_all_pinned();
        do_reset();
        for (int i = 0; i < N; i++) fill('h3000 + i, 4, i + 16, 1, 1, 1, 1);
        fill('h3FFF, 4, 'h999, 1, 1, 1, 0);
        look("R12 refill dropped", 'h3FFF, 4, 0, 0, 0, 0);
        look("R12 entry 0 intact", 'h3000, 4, 0, 0, 1, 16);
        look("R12 last entry intact", 'h3000 + N - 1, 4, 0, 0, 1, N - 1 + 16);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        t_reset();
        t_idle();
        t_basic();
        t_perm();
        t_update();
        t_inval();
        t_flush();
        t_prio();
        t_replace();
        t_all_pinned();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule